// File: doc/BRIEF.md
# Lookahead Four-Function ALU

This block is the arithmetic unit of a small accumulator machine, written as pure combinational logic. It takes two operand words and a group of operation-select lines and returns one result word in the same evaluation. Operand A holds the word fetched from memory and operand B holds the saved accumulator copy. The supported operations are add, subtract, shift left, shift right, increment and transfer.

All adder-based operations share one adder. In that adder, every bit's carry is built in parallel as a sum of products of the generate and propagate terms and the carry in, so no carry waits on its neighbour. Subtraction complements operand A and forces the carry in high, which gives B minus A in two's complement. The increment mode feeds zero in place of B and forces the carry in high, and the program counter uses it to step. The carry out of the top bit is dropped. If no select line is active, the result is zero. The block produces no status flags.

Top module: `la_alu`

## Requirements
- R1: With only the add select active (sel_i bit 0), result_o equals (opa_i + opb_i) mod 2^WIDTH.
- R2: With only the subtract select active (sel_i bit 1), result_o equals (opb_i - opa_i) mod 2^WIDTH, formed as ~opa_i + opb_i + 1.
- R3: The carry into every bit is computed directly from the operands and the carry in, and it equals the carry a bit-serial chain would give. The result is correct for operands whose carry runs the full width.
- R4: With only the shift-left select active (sel_i bit 2), result_o equals opa_i moved up one place with 0 in bit 0. The top bit of opa_i is lost.
- R5: With only the shift-right select active (sel_i bit 3), result_o equals opa_i moved down one place with the top bit copied from opa_i's top bit.
- R6: With only the increment select active (sel_i bit 4), result_o equals (opa_i + 1) mod 2^WIDTH, and opb_i has no effect.
- R7: With only the transfer select active (sel_i bit 5), result_o equals opa_i, and opb_i has no effect.
- R8: At most one select is active at a time. With sel_i all zero, result_o is 0 whatever the operands hold.
- R9: The carry out of the top bit is discarded. An add, increment or subtract that overflows wraps modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | Operand A, the memory word |
| opb_i | input | WIDTH | Operand B, the accumulator copy |
| sel_i | input | 6 | One-hot operation select: bit 0 add, 1 subtract, 2 shift left, 3 shift right, 4 increment, 5 transfer |
| result_o | output | WIDTH | Operation result |

## Verification
The bench builds the block with the default WIDTH of 8. At that width the all-ones operands, the sign-bit boundaries at 0x7F and 0x80, and carries that run the full eight bits can all be chosen directly as test values. A pseudo-random sweep over every select then compares each result against an integer model. This exercises wrapping on add, increment and subtract, sign copying on shift right and bit loss on shift left. It also confirms that operand B is ignored in the increment and transfer modes.

// File: rtl/la_alu_pkg.sv
package la_alu_pkg;
  localparam int SEL_ADD = 0;
  localparam int SEL_SUB = 1;
  localparam int SEL_SHL = 2;
  localparam int SEL_SHR = 3;
  localparam int SEL_INC = 4;
  localparam int SEL_XFR = 5;
  localparam int NUM_SEL = 6;

  typedef logic [NUM_SEL-1:0] sel_vec_t;

  function automatic sel_vec_t sel_mask(input int idx);
    sel_vec_t m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/la_alu_carry.sv
module la_alu_carry #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  input  logic             cin_i,
  output logic [WIDTH:0]   carry_o
);
  assign carry_o[0] = cin_i;

  for (genvar i = 1; i <= WIDTH; i++) begin : g_carry
    always_comb begin
      logic acc;
      logic term;
      // carry in propagated through every lower bit
      term = cin_i;
      for (int k = 0; k < i; k++) term = term & prop_i[k];
      acc = term;
      // each lower generate propagated through the bits above it
      for (int j = 0; j < i; j++) begin
        term = gen_i[j];
        for (int k = j + 1; k < i; k++) term = term & prop_i[k];
        acc = acc | term;
      end
      carry_o[i] = acc;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    always_comb begin
      // R3
      chain_match_chk: assert (carry_o[i+1] == (gen_i[i] | (prop_i[i] & carry_o[i])));
    end
  end
endmodule

// File: rtl/la_alu_adder.sv
module la_alu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] gen_w;
  logic [WIDTH-1:0] prop_w;
  logic [WIDTH:0]   carry_w;

  function automatic logic [WIDTH-1:0] sum_bits(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b,
                                                input logic [WIDTH-1:0] c);
    return a ^ b ^ c;
  endfunction

  assign gen_w  = a_i & b_i;
  assign prop_w = a_i | b_i;

  la_alu_carry #(.WIDTH(WIDTH)) carry_i (
    .gen_i   (gen_w),
    .prop_i  (prop_w),
    .cin_i   (cin_i),
    .carry_o (carry_w)
  );

  assign sum_o  = sum_bits(a_i, b_i, carry_w[WIDTH-1:0]);
  assign cout_o = carry_w[WIDTH];
endmodule

// File: rtl/la_alu_shift.sv
module la_alu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] shl_o,
  output logic [WIDTH-1:0] shr_o
);
  function automatic logic [WIDTH-1:0] up_one(input logic [WIDTH-1:0] v);
    return {v[WIDTH-2:0], 1'b0};
  endfunction

  function automatic logic [WIDTH-1:0] down_keep(input logic [WIDTH-1:0] v);
    return {v[WIDTH-1], v[WIDTH-1:1]};
  endfunction

  assign shl_o = up_one(a_i);
  assign shr_o = down_keep(a_i);

  always_comb begin
    // R4
    shl_low_chk: assert (shl_o[0] == 1'b0);
  end
endmodule

// File: rtl/la_alu.sv
module la_alu
  import la_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   opa_i,
  input  logic [WIDTH-1:0]   opb_i,
  input  logic [NUM_SEL-1:0] sel_i,
  output logic [WIDTH-1:0]   result_o
);
  logic             sub_w;
  logic             inc_w;
  logic [WIDTH-1:0] add_a_w;
  logic [WIDTH-1:0] add_b_w;
  logic             add_cin_w;
  logic [WIDTH-1:0] sum_w;
  logic             cout_w;
  logic [WIDTH-1:0] shl_w;
  logic [WIDTH-1:0] shr_w;
  logic [WIDTH-1:0] cand_w [NUM_SEL];
  logic [WIDTH-1:0] gated_w [NUM_SEL];

  assign sub_w     = sel_i[SEL_SUB];
  assign inc_w     = sel_i[SEL_INC];
  assign add_a_w   = sub_w ? ~opa_i : opa_i;
  assign add_b_w   = inc_w ? '0 : opb_i;
  assign add_cin_w = sub_w | inc_w;

  la_alu_adder #(.WIDTH(WIDTH)) adder_i (
    .a_i    (add_a_w),
    .b_i    (add_b_w),
    .cin_i  (add_cin_w),
    .sum_o  (sum_w),
    .cout_o (cout_w)
  );

  la_alu_shift #(.WIDTH(WIDTH)) shift_i (
    .a_i   (opa_i),
    .shl_o (shl_w),
    .shr_o (shr_w)
  );

  assign cand_w[SEL_ADD] = sum_w;
  assign cand_w[SEL_SUB] = sum_w;
  assign cand_w[SEL_SHL] = shl_w;
  assign cand_w[SEL_SHR] = shr_w;
  assign cand_w[SEL_INC] = sum_w;
  assign cand_w[SEL_XFR] = opa_i;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_gate
    assign gated_w[i] = cand_w[i] & {WIDTH{sel_i[i]}};
  end

  always_comb begin
    result_o = '0;
    for (int i = 0; i < NUM_SEL; i++) result_o = result_o | gated_w[i];
  end

  always_comb begin
    // R8
    sel_onehot_chk: assert ($onehot0(sel_i));
    // R8
    idle_zero_chk: assert (sel_i != '0 || result_o == '0);
    // R1
    add_sum_chk: assert (sel_i != sel_mask(SEL_ADD) || result_o == WIDTH'(opa_i + opb_i));
    // R2
    sub_diff_chk: assert (sel_i != sel_mask(SEL_SUB) || result_o == WIDTH'(opb_i - opa_i));
    // R5
    shr_sign_chk: assert (sel_i != sel_mask(SEL_SHR) || result_o[WIDTH-1] == opa_i[WIDTH-1]);
    // R6
    inc_step_chk: assert (sel_i != sel_mask(SEL_INC) || result_o == WIDTH'(opa_i + 1'b1));
    // R9
    add_wrap_chk: assert (sel_i != sel_mask(SEL_ADD) || !cout_w || result_o < opa_i);
  end
endmodule

// File: tb/la_alu_tb_top.sv
module la_alu_tb_top;
  localparam int W   = 8;
  localparam int MOD = 1 << W;
  localparam int NS  = 6;

  logic         clk;
  logic         rst;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [NS-1:0] sel;
  logic [W-1:0] result;

  int checks;
  int errors;
  bit done;

  // current stimulus, as seen by the model
  int cur_a;
  int cur_b;
  int cur_op;   // -1 none, 0..5 operation
  string cur_tag;

  la_alu #(.WIDTH(W)) dut_i (
    .opa_i    (opa),
    .opb_i    (opb),
    .sel_i    (sel),
    .result_o (result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int model(input int a, input int b, input int op);
    case (op)
      0: return (a + b) % MOD;
      1: return (b - a + MOD) % MOD;
      2: return (a * 2) % MOD;
      3: return (a / 2) + ((a >= MOD / 2) ? MOD / 2 : 0);
      4: return (a + 1) % MOD;
      5: return a;
      default: return 0;
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input int a, input int b, input int op, input string tag);
    @(posedge clk);
    opa = W'(a);
    opb = W'(b);
    sel = (op < 0) ? '0 : NS'(1 << op);
    cur_a = a;
    cur_b = b;
    cur_op = op;
    cur_tag = tag;
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      int exp;
      exp = rst ? 0 : model(cur_a, cur_b, cur_op);
      checks++;
      if (int'(result) != exp) begin
        errors++;
        $display("FAIL %s op=%0d a=%0h b=%0h actual=%0h expected=%0h",
                 rst ? "R8" : cur_tag, cur_op, cur_a, cur_b, result, exp);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    checks = 0;
    errors = 0;
    done = 1'b0;
    rst = 1'b1;
    opa = 8'hA5;
    opb = 8'h3C;
    sel = '0;
    cur_a = 8'hA5;
    cur_b = 8'h3C;
    cur_op = -1;
    cur_tag = "R8";
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R8 idle with busy operands
    apply(8'hFF, 8'hFF, -1, "R8");
    apply(8'h12, 8'h34, -1, "R8");
    // R1 plain add
    apply(8'h12, 8'h34, 0, "R1");
    apply(8'h00, 8'h00, 0, "R1");
    // R3 full-width carry chains
    apply(8'h01, 8'h7F, 0, "R3");
    apply(8'h55, 8'hAB, 0, "R3");
    apply(8'h0F, 8'h01, 0, "R3");
    // R9 wrapping
    apply(8'hFF, 8'h01, 0, "R9");
    apply(8'h80, 8'h80, 0, "R9");
    apply(8'hFF, 8'h00, 4, "R9");
    apply(8'h01, 8'h00, 1, "R9");
    // R2 subtract B - A
    apply(8'h05, 8'h09, 1, "R2");
    apply(8'h09, 8'h09, 1, "R2");
    apply(8'h00, 8'h80, 1, "R2");
    // R4 shift left
    apply(8'h81, 8'h00, 2, "R4");
    apply(8'h7F, 8'hFF, 2, "R4");
    // R5 shift right keeps sign
    apply(8'h80, 8'h00, 3, "R5");
    apply(8'h7F, 8'h00, 3, "R5");
    apply(8'h01, 8'hFF, 3, "R5");
    // R6 increment ignores B
    apply(8'h7F, 8'hFF, 4, "R6");
    apply(8'h10, 8'hAA, 4, "R6");
    // R7 transfer ignores B
    apply(8'hC3, 8'h5A, 5, "R7");
    apply(8'h00, 8'hFF, 5, "R7");

    // pseudo-random sweep over all selects
    lfsr = 32'h1ACE;
    for (int n = 0; n < 1400; n++) begin
      int a;
      int b;
      int op;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      a = lfsr & 8'hFF;
      b = (lfsr >> 8) & 8'hFF;
      op = (n % 7) - 1;
      apply(a, b, op, op_tag(op));
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule